// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block stands between a memory-access sequencer and the command pins of a single chip-select synchronous DRAM. The sequencer offers one command at a time (activate, read, write, precharge, refresh) over a valid/ready handshake. The block holds each request until every spacing rule that applies to it has run out. It then grants the request and drives the command on registered outputs one cycle later. In every cycle without a grant, the command output is NOP.

The spacing rules come from a configuration word with five parts. The first four are 2-bit codes: activate-to-access delay, write recovery, refresh lockout, and precharge time. The fifth is a mode bit. The lockout after a write and the lockout after a refresh are each the precharge time plus the field's own delay. When the mode bit is 0, every read and write is sent with auto-precharge, so its row closes. When the mode bit is 1, the row stays open. The block remembers which row is open. An access to the open row goes out directly. An access to any other row makes the block insert a precharge and then an activate on its own before it grants the access.

Top module: `sdram_cmd_timer`

## Requirements
- R1: After reset, cmd_out is NOP (0) and config_error is 0. All lockouts start expired, so the first request is granted in the cycle it is presented.
- R2: A READ (cmd 2) or WRITE (cmd 3) issues no earlier than cfg_rcd+1 cycles after the last ACT (cmd 1).
- R3: After a WRITE, no ACT or REFRESH issues for TPC+W cycles. TPC is cfg_tpc+1. W is cfg_wpd+1 for codes 0 to 2, and 3 for the reserved code 3. Programming code 3 sets config_error, which stays set until reset.
- R4: After a REFRESH (cmd 5), no ACT or REFRESH issues for TPC+cfg_rfd+2 cycles.
- R5: After a PRE (cmd 4) or an auto-precharged READ, no ACT or REFRESH issues for TPC cycles.
- R6: A PRE issues no earlier than W cycles after the last WRITE.
- R7: With cfg_bank_open=0, every READ and WRITE is output with cmd_ap=1 and closes the row. The next access to any row is preceded by an inserted ACT carrying that row on cmd_row.
- R8: With cfg_bank_open=1, an access to the open row issues without an ACT. An access to a different row first issues an inserted PRE and then an inserted ACT. An ACT or REFRESH request that arrives while a row is open also gets an inserted PRE first.
- R9: req_ready is high only in a cycle where the requested command itself is issued. That command appears on cmd_out in the next cycle. Codes 0, 6 and 7 are accepted at once and issue nothing.
- R10: Every command, requested or inserted, issues in the first cycle in which all of its spacing rules are met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rcd | input | 2 | Activate-to-access delay code (1 to 4 cycles) |
| cfg_wpd | input | 2 | Write recovery code (1 to 3 cycles, code 3 reserved) |
| cfg_rfd | input | 2 | Refresh lockout code (2 to 5 cycles) |
| cfg_tpc | input | 2 | Precharge time code (1 to 4 cycles) |
| cfg_bank_open | input | 1 | 1 keeps rows open, 0 auto-precharges each access |
| req_valid | input | 1 | Request offered |
| req_cmd | input | 3 | Requested command: 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 REFRESH |
| req_row | input | ROW_W | Row address of the request |
| req_ready | output | 1 | Request granted this cycle |
| cmd_out | output | 3 | Issued command, same encoding, 0 = NOP |
| cmd_ap | output | 1 | Auto-precharge flag for an issued READ or WRITE |
| cmd_row | output | ROW_W | Row of an issued ACT, otherwise 0 |
| config_error | output | 1 | Sticky flag for the reserved write-recovery code |

## Verification
The bench builds the block with ROW_W=4 and the default CNT_W=4. With these values the bench can cover every combination of the four delay codes and the mode bit, 512 configurations, with each one running the same request program. That program includes row hits, row misses, explicit precharges and refreshes. Each cycle, a timestamp model predicts the exact command, and a separate check measures every gap between issued commands against the decoded delays. This exposes both a stall that is too short and a single cycle of extra stall.

// File: rtl/sdram_timer_pkg.sv
package sdram_timer_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_ACT   = 3'd1,
      CMD_READ  = 3'd2,
      CMD_WRITE = 3'd3,
      CMD_PRE   = 3'd4,
      CMD_REF   = 3'd5
   } sdram_cmd_e;

   // lockout counter slots
   localparam int LK_ACT   = 0;
   localparam int LK_RW    = 1;
   localparam int LK_PRE   = 2;
   localparam int NUM_LOCK = 3;

   localparam int CODE_W = 2;

endpackage

// File: rtl/sdram_delay_decode.sv
module sdram_delay_decode #(
   parameter int CNT_W = 4
) (
   input  logic [1:0]       code_rcd,
   input  logic [1:0]       code_wpd,
   input  logic [1:0]       code_rfd,
   input  logic [1:0]       code_tpc,
   output logic [CNT_W-1:0] dly_rcd,
   output logic [CNT_W-1:0] dly_wpd,
   output logic [CNT_W-1:0] dly_rfd,
   output logic [CNT_W-1:0] dly_tpc,
   output logic             wpd_reserved
);

   always_comb begin
      dly_rcd      = CNT_W'(code_rcd) + CNT_W'(1);
      dly_tpc      = CNT_W'(code_tpc) + CNT_W'(1);
      dly_rfd      = CNT_W'(code_rfd) + CNT_W'(2);
      wpd_reserved = (code_wpd == 2'b11);
      dly_wpd      = wpd_reserved ? CNT_W'(3) : (CNT_W'(code_wpd) + CNT_W'(1));
   end

endmodule

// File: rtl/sdram_lockout_ctr.sv
module sdram_lockout_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             is_zero
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_dec;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_dec = (cnt == '0) ? '0 : cnt - CNT_W'(1);
      cnt_nxt = (load && (load_val > cnt_dec)) ? load_val : cnt_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assign is_zero = (cnt == '0);

   // R10
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R10
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt >= $past(load_val)));

endmodule

// File: rtl/sdram_issue_arbiter.sv
module sdram_issue_arbiter
   import sdram_timer_pkg::*;
#(
   parameter int ROW_W = 12
) (
   input  logic             req_valid,
   input  logic [2:0]       req_cmd,
   input  logic [ROW_W-1:0] req_row,
   input  logic             row_open,
   input  logic [ROW_W-1:0] open_row,
   input  logic             bank_mode,
   input  logic             act_ok,
   input  logic             rw_ok,
   input  logic             pre_ok,
   output sdram_cmd_e       issue_cmd,
   output logic             issue_ap,
   output logic             grant
);

   logic row_hit;
   assign row_hit = row_open && (open_row == req_row);

   always_comb begin
      issue_cmd = CMD_NOP;
      issue_ap  = 1'b0;
      grant     = 1'b0;
      if (req_valid) begin
         case (req_cmd)
            3'd1: begin
               if (row_open) begin
                  if (pre_ok) issue_cmd = CMD_PRE;
               end else if (act_ok) begin
                  issue_cmd = CMD_ACT;
                  grant     = 1'b1;
               end
            end
            3'd2, 3'd3: begin
               if (row_hit) begin
                  if (rw_ok) begin
                     issue_cmd = (req_cmd == 3'd2) ? CMD_READ : CMD_WRITE;
                     issue_ap  = !bank_mode;
                     grant     = 1'b1;
                  end
               end else if (row_open) begin
                  if (pre_ok) issue_cmd = CMD_PRE;
               end else if (act_ok) begin
                  issue_cmd = CMD_ACT;
               end
            end
            3'd4: begin
               if (pre_ok) begin
                  issue_cmd = CMD_PRE;
                  grant     = 1'b1;
               end
            end
            3'd5: begin
               if (row_open) begin
                  if (pre_ok) issue_cmd = CMD_PRE;
               end else if (act_ok) begin
                  issue_cmd = CMD_REF;
                  grant     = 1'b1;
               end
            end
            default: grant = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
   import sdram_timer_pkg::*;
#(
   parameter int ROW_W = 12,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_rcd,
   input  logic [1:0]       cfg_wpd,
   input  logic [1:0]       cfg_rfd,
   input  logic [1:0]       cfg_tpc,
   input  logic             cfg_bank_open,
   input  logic             req_valid,
   input  logic [2:0]       req_cmd,
   input  logic [ROW_W-1:0] req_row,
   output logic             req_ready,
   output logic [2:0]       cmd_out,
   output logic             cmd_ap,
   output logic [ROW_W-1:0] cmd_row,
   output logic             config_error
);

   // longest lockout: 4 (precharge) + 5 (refresh) - 1 must fit
   localparam int MAX_LOCK = 8;

   if (CNT_W < $clog2(MAX_LOCK + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest lockout");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be at least 1");
   end

   logic [CNT_W-1:0] dly_rcd, dly_wpd, dly_rfd, dly_tpc;
   logic             wpd_reserved;

   sdram_delay_decode #(.CNT_W(CNT_W)) u_decode (
      .code_rcd     (cfg_rcd),
      .code_wpd     (cfg_wpd),
      .code_rfd     (cfg_rfd),
      .code_tpc     (cfg_tpc),
      .dly_rcd      (dly_rcd),
      .dly_wpd      (dly_wpd),
      .dly_rfd      (dly_rfd),
      .dly_tpc      (dly_tpc),
      .wpd_reserved (wpd_reserved)
   );

   logic [NUM_LOCK-1:0] lk_load;
   logic [NUM_LOCK-1:0] lk_zero;
   logic [CNT_W-1:0]    lk_val [NUM_LOCK];

   for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
      sdram_lockout_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (lk_load[g]),
         .load_val (lk_val[g]),
         .is_zero  (lk_zero[g])
      );
   end

   logic             row_open;
   logic [ROW_W-1:0] open_row;
   sdram_cmd_e       issue_cmd;
   logic             issue_ap;

   sdram_issue_arbiter #(.ROW_W(ROW_W)) u_arb (
      .req_valid (req_valid),
      .req_cmd   (req_cmd),
      .req_row   (req_row),
      .row_open  (row_open),
      .open_row  (open_row),
      .bank_mode (cfg_bank_open),
      .act_ok    (lk_zero[LK_ACT]),
      .rw_ok     (lk_zero[LK_RW]),
      .pre_ok    (lk_zero[LK_PRE]),
      .issue_cmd (issue_cmd),
      .issue_ap  (issue_ap),
      .grant     (req_ready)
   );

   // lockout loads: a gap of N cycles loads N-1
   always_comb begin
      lk_load = '0;
      lk_val[LK_ACT] = '0;
      lk_val[LK_RW]  = dly_rcd - CNT_W'(1);
      lk_val[LK_PRE] = dly_wpd - CNT_W'(1);
      case (issue_cmd)
         CMD_ACT: lk_load[LK_RW] = 1'b1;
         CMD_WRITE: begin
            lk_load[LK_ACT] = 1'b1;
            lk_load[LK_PRE] = 1'b1;
            lk_val[LK_ACT]  = dly_tpc + dly_wpd - CNT_W'(1);
         end
         CMD_READ: begin
            lk_load[LK_ACT] = issue_ap;
            lk_val[LK_ACT]  = dly_tpc - CNT_W'(1);
         end
         CMD_PRE: begin
            lk_load[LK_ACT] = 1'b1;
            lk_val[LK_ACT]  = dly_tpc - CNT_W'(1);
         end
         CMD_REF: begin
            lk_load[LK_ACT] = 1'b1;
            lk_val[LK_ACT]  = dly_tpc + dly_rfd - CNT_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open     <= 1'b0;
         open_row     <= '0;
         cmd_out      <= 3'd0;
         cmd_ap       <= 1'b0;
         cmd_row      <= '0;
         config_error <= 1'b0;
      end else begin
         cmd_out      <= issue_cmd;
         cmd_ap       <= issue_ap;
         cmd_row      <= (issue_cmd == CMD_ACT) ? req_row : '0;
         config_error <= config_error | wpd_reserved;
         case (issue_cmd)
            CMD_ACT: begin
               row_open <= 1'b1;
               open_row <= req_row;
            end
            CMD_PRE: row_open <= 1'b0;
            CMD_READ, CMD_WRITE: if (issue_ap) row_open <= 1'b0;
            default: ;
         endcase
      end
   end

   // R9
   grant_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_cmd >= 3'd1 && req_cmd <= 3'd5)
      |=> (cmd_out == $past(req_cmd)));

   // R8
   act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_cmd == CMD_ACT) |-> !row_open);

   // R2
   rw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_cmd == CMD_READ || issue_cmd == CMD_WRITE) |-> lk_zero[LK_RW]);

   // R3
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |=> config_error);

   // R7
   ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ap |=> !row_open);

endmodule

// File: tb/tb_sdram_cmd_timer.sv
module tb_sdram_cmd_timer;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 4;
   localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       cfg_rcd = 2'd0, cfg_wpd = 2'd0, cfg_rfd = 2'd0, cfg_tpc = 2'd0;
   logic             cfg_bank_open = 1'b0;
   logic             req_valid = 1'b0;
   logic [2:0]       req_cmd = 3'd0;
   logic [ROW_W-1:0] req_row = '0;
   logic             req_ready;
   logic [2:0]       cmd_out;
   logic             cmd_ap;
   logic [ROW_W-1:0] cmd_row;
   logic             config_error;

   sdram_cmd_timer #(.ROW_W(ROW_W), .CNT_W(4)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_rcd(cfg_rcd), .cfg_wpd(cfg_wpd), .cfg_rfd(cfg_rfd), .cfg_tpc(cfg_tpc),
      .cfg_bank_open(cfg_bank_open),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_row(req_row), .req_ready(req_ready),
      .cmd_out(cmd_out), .cmd_ap(cmd_ap), .cmd_row(cmd_row), .config_error(config_error)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit finished = 0;

   // model timestamps (decision cycle) and observed timestamps (output cycle)
   int m_act = -100, m_wr = -100, m_pre = -100, m_ref = -100, m_apr = -100;
   int a_act = -100, a_wr = -100, a_pre = -100, a_ref = -100, a_apr = -100;
   bit m_open = 0;
   int m_row = 0;
   bit m_err = 0;
   bit last_ready;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int d_wpd();
      return (cfg_wpd == 2'd3) ? 3 : int'(cfg_wpd) + 1;
   endfunction

   // one clock: predict, check grant, then check registered output
   task automatic tick();
      int rcd, wpd, rfd, tpc, e_cmd, e_row;
      bit act_ok, rw_ok, pre_ok, e_grant, e_ap, hit;
      #1;
      rcd = int'(cfg_rcd) + 1; wpd = d_wpd(); rfd = int'(cfg_rfd) + 2; tpc = int'(cfg_tpc) + 1;
      act_ok = (cyc >= m_wr + tpc + wpd) && (cyc >= m_ref + tpc + rfd) &&
               (cyc >= m_pre + tpc) && (cyc >= m_apr + tpc);
      rw_ok  = (cyc >= m_act + rcd);
      pre_ok = (cyc >= m_wr + wpd);
      hit    = m_open && (m_row == int'(req_row));
      e_cmd = C_NOP; e_grant = 0; e_ap = 0; e_row = 0;
      if (req_valid) begin
         case (int'(req_cmd))
            C_ACT: if (m_open) begin if (pre_ok) e_cmd = C_PRE; end
                   else if (act_ok) begin e_cmd = C_ACT; e_grant = 1; end
            C_RD, C_WR: if (hit) begin
                           if (rw_ok) begin e_cmd = int'(req_cmd); e_ap = !cfg_bank_open; e_grant = 1; end
                        end else if (m_open) begin if (pre_ok) e_cmd = C_PRE; end
                        else if (act_ok) e_cmd = C_ACT;
            C_PRE: if (pre_ok) begin e_cmd = C_PRE; e_grant = 1; end
            C_REF: if (m_open) begin if (pre_ok) e_cmd = C_PRE; end
                   else if (act_ok) begin e_cmd = C_REF; e_grant = 1; end
            default: e_grant = 1;
         endcase
      end
      if (e_cmd == C_ACT) e_row = int'(req_row);
      // R9 grant only when the requested command itself goes out
      chk(req_ready == e_grant, "R9 req_ready", int'(req_ready), int'(e_grant));
      last_ready = req_ready;
      case (e_cmd)
         C_ACT: begin m_act = cyc; m_open = 1; m_row = int'(req_row); end
         C_RD:  if (e_ap) begin m_apr = cyc; m_open = 0; end
         C_WR:  begin m_wr = cyc; if (e_ap) m_open = 0; end
         C_PRE: begin m_pre = cyc; m_open = 0; end
         C_REF: m_ref = cyc;
         default: ;
      endcase
      m_err = m_err | (cfg_wpd == 2'd3);
      @(negedge clk);
      cyc++;
      // R10 exact earliest command; R7 / R8 mode behaviour
      chk(int'(cmd_out) == e_cmd, cfg_bank_open ? "R10/R8 cmd" : "R10/R7 cmd", int'(cmd_out), e_cmd);
      chk(cmd_ap == e_ap, "R7 cmd_ap", int'(cmd_ap), int'(e_ap));
      chk(int'(cmd_row) == e_row, "R7 cmd_row", int'(cmd_row), e_row);
      chk(config_error == m_err, "R3 config_error", int'(config_error), int'(m_err));
      // independent gap measurements on the observed stream
      case (int'(cmd_out))
         C_ACT, C_REF: begin
            chk(cyc - a_wr >= tpc + wpd, "R3 write lockout", cyc - a_wr, tpc + wpd);
            chk(cyc - a_ref >= tpc + rfd, "R4 refresh lockout", cyc - a_ref, tpc + rfd);
            chk(cyc - a_pre >= tpc, "R5 precharge lockout", cyc - a_pre, tpc);
            chk(cyc - a_apr >= tpc, "R5 auto-precharge lockout", cyc - a_apr, tpc);
            if (int'(cmd_out) == C_ACT) a_act = cyc; else a_ref = cyc;
         end
         C_RD, C_WR: begin
            chk(cyc - a_act >= rcd, "R2 act to access", cyc - a_act, rcd);
            if (int'(cmd_out) == C_WR) a_wr = cyc;
            else if (cmd_ap) a_apr = cyc;
         end
         C_PRE: begin
            chk(cyc - a_wr >= wpd, "R6 write to precharge", cyc - a_wr, wpd);
            a_pre = cyc;
         end
         default: ;
      endcase
   endtask

   task automatic issue_req(input int cmd, input int row);
      int waited = 0;
      req_valid = 1'b1; req_cmd = 3'(cmd); req_row = ROW_W'(row);
      last_ready = 0;
      while (!last_ready && waited < 40) begin
         tick();
         waited++;
      end
      chk(last_ready, "R10 request stalled", waited, 40);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      repeat (n) tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_out == 3'd0, "R1 cmd_out reset", int'(cmd_out), 0);
      chk(config_error == 1'b0, "R1 config_error reset", int'(config_error), 0);
      // R1 first request undelayed: refresh granted at once
      req_valid = 1'b1; req_cmd = 3'(C_REF);
      tick();
      chk(last_ready == 1'b1, "R1 first request", int'(last_ready), 1);
      req_valid = 1'b0;
      idle(12);
      // R9 unused code consumed with no command
      issue_req(6, 0);
      idle(12);
      for (int md = 0; md < 2; md++)
         for (int tp = 0; tp < 4; tp++)
            for (int rf = 0; rf < 4; rf++)
               for (int rc = 0; rc < 4; rc++)
                  for (int wp = 0; wp < 4; wp++) begin
                     int k = md + tp + rf + rc + wp;
                     cfg_bank_open = 1'(md); cfg_tpc = 2'(tp); cfg_rfd = 2'(rf);
                     cfg_rcd = 2'(rc); cfg_wpd = 2'(wp);
                     idle(12);
                     issue_req(C_WR, 1);  idle(k % 2);
                     issue_req(C_RD, 1);
                     issue_req(C_WR, 2);  idle(k % 3);
                     issue_req(C_PRE, 0);
                     issue_req(C_REF, 0);
                     issue_req(C_RD, 2);
                     issue_req(C_WR, 2);
                     issue_req(C_ACT, 3); idle((k + 1) % 3);
                     issue_req(C_WR, 3);
                     issue_req(C_REF, 0);
                     issue_req(C_RD, 3);
                  end
      idle(12);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule